// File: doc/BRIEF.md
# Reset Generator With Watchdog

This block merges three independent causes of system reset into a single active-high reset line. The three causes are a cold-start hold after power-on, a debounced external reset pin, and a watchdog that software has to clear. The watchdog advances on a one-per-second tick from the prescaler. Software sees it through a 4-bit register that holds a clear bit, the two watchdog counter bits and a general interrupt-enable bit.

A single status output carries two kinds of information. It stays high for as long as any reset is in force. When the chip is running, it gives a half-clock pulse after every write to an output port, so external logic can tell when the port pins change.

The power-on indication also acts as the block's own synchronous reset. The block does not contain the analog detector that produces it.

Top module: `rstgen_top`

## Requirements
- R1: After the power-on input is sampled low, the system reset stays high for exactly COLD_CYCLES further clock edges. It is low after edge number COLD_CYCLES.
- R2: The reset pin is accepted only once it has been sampled high on DEBOUNCE_CYCLES consecutive edges. The system reset then rises after that edge and stays high until the first edge that samples the pin low. A shorter high pulse has no effect.
- R3: Each tick at 1 Hz advances a 2-bit watchdog count by one. The count reads back on register bits 2:1, with bit 2 as the more significant bit.
- R4: A tick that arrives while the count is 3 returns the count to 0. When WDOG_ENABLE is nonzero, it also raises the system reset for exactly one cycle after that edge.
- R5: Writing the register with bit 3 set clears the count, and this clear takes priority over a tick in the same cycle. Bit 3 always reads 0.
- R6: Register bit 0 is a read/write interrupt enable. Writes to bits 2:1 are ignored.
- R7: While the system reset is high, ticks are ignored. The edge after any reset leaves every register bit at 0.
- R8: With WDOG_ENABLE = 0, the count still wraps, but the watchdog never raises the system reset.
- R9: The status output is high for the whole time the system reset is high, in both clock phases.
- R10: A port write sampled at an edge makes the status output high during the high half of the following clock cycle. The output is low again in the low half and stays low after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on indication; also synchronous reset of the block |
| rst_pin_i | input | 1 | External reset pin, active high, not yet debounced |
| tick_1hz_i | input | 1 | One-cycle tick from the prescaler, once per second |
| wd_wr_i | input | 1 | Write strobe for the watchdog register |
| wd_wdata_i | input | 4 | Write data: bit 3 clear, bit 0 interrupt enable |
| wd_rdata_o | output | 4 | Read data: {0, count[1], count[0], interrupt enable} |
| port_wr_i | input | 1 | Write to either output port |
| sys_rst_o | output | 1 | Combined system reset, active high |
| strobe_o | output | 1 | Status output: reset level or half-cycle write pulse |

## Verification
The bench builds the design with COLD_CYCLES = 16 and DEBOUNCE_CYCLES = 4. With these values, the exact release edge of the cold-start hold, and the edge that separates a rejected pin pulse from an accepted one, can be checked cycle by cycle in a short run. The full one-second and 2 ms values would take far too many cycles. A second instance with WDOG_ENABLE = 0 receives the same stimulus as the first, so the wrap without a reset can be compared directly with the enabled variant.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    localparam int WD_REG_W = 4;
    localparam int WD_CNT_W = 2;

    typedef logic [WD_CNT_W-1:0] wd_cnt_t;

    // register read layout; bit order is decoded by software
    typedef struct packed {
        logic    zero;   // bit 3: clear bit, reads 0
        wd_cnt_t cnt;    // bits 2:1: watchdog count
        logic    ien;    // bit 0: interrupt enable
    } wd_reg_t;

    typedef struct packed {
        logic cold;
        logic pin;
        logic wdog;
    } rst_src_t;

    localparam wd_cnt_t WD_CNT_MAX = '1;

    function automatic int ctr_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rstgen_cold.sv
module rstgen_cold #(
    parameter int HOLD_CYCLES = 32768
) (
    input  logic clk,
    input  logic por_i,
    output logic hold_o
);
    localparam int CW = rstgen_pkg::ctr_bits(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          hold_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            cnt_q  <= '0;
            hold_q <= 1'b1;
        end else if (hold_q) begin
            if (cnt_q == LAST) begin
                hold_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign hold_o = hold_q;
endmodule

// File: rtl/rstgen_debounce.sv
module rstgen_debounce #(
    parameter int STABLE_CYCLES = 64
) (
    input  logic clk,
    input  logic por_i,
    input  logic pin_i,
    output logic accept_o
);
    localparam int CW = rstgen_pkg::ctr_bits(STABLE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          acc_q;

    always_ff @(posedge clk) begin
        if (por_i || !pin_i) begin
            cnt_q <= '0;
            acc_q <= 1'b0;
        end else if (!acc_q) begin
            if (cnt_q == LAST) begin
                acc_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign accept_o = acc_q;
endmodule

// File: rtl/rstgen_wdog.sv
module rstgen_wdog
    import rstgen_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic    clk,
    input  logic    por_i,
    input  logic    sys_rst_i,
    input  logic    tick_i,
    input  logic    wr_i,
    input  logic    clr_i,
    input  logic    ien_i,
    output wd_reg_t rdata_o,
    output logic    fire_o
);
    wd_cnt_t cnt_q;
    logic    ien_q;
    logic    fire_q;

    always_ff @(posedge clk) begin
        if (por_i || sys_rst_i) begin
            cnt_q  <= '0;
            ien_q  <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (wr_i) begin
                ien_q <= ien_i;
            end
            if (wr_i && clr_i) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q == WD_CNT_MAX) begin
                    cnt_q  <= '0;
                    fire_q <= ENABLE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        rdata_o.zero = 1'b0;
        rdata_o.cnt  = cnt_q;
        rdata_o.ien  = ien_q;
    end

    assign fire_o = fire_q;
endmodule

// File: rtl/rstgen_strobe.sv
module rstgen_strobe (
    input  logic clk,
    input  logic por_i,
    input  logic rst_i,
    input  logic wr_i,
    output logic strobe_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= wr_i;
        end
    end

    // reset level dominates; otherwise the pulse spans the high clock phase
    assign strobe_o = rst_i | (pend_q & clk);
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
    import rstgen_pkg::*;
#(
    parameter int COLD_CYCLES     = 32768,
    parameter int DEBOUNCE_CYCLES = 64,
    parameter bit WDOG_ENABLE     = 1'b1
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       rst_pin_i,
    input  logic       tick_1hz_i,
    input  logic       wd_wr_i,
    input  logic [3:0] wd_wdata_i,
    output logic [3:0] wd_rdata_o,
    input  logic       port_wr_i,
    output logic       sys_rst_o,
    output logic       strobe_o
);
    rst_src_t src;
    wd_reg_t  rd;
    logic     unused_ro_bits;

    assign unused_ro_bits = ^wd_wdata_i[2:1];

    rstgen_cold #(.HOLD_CYCLES(COLD_CYCLES)) u_cold (
        .clk    (clk),
        .por_i  (por_i),
        .hold_o (src.cold)
    );

    rstgen_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk      (clk),
        .por_i    (por_i),
        .pin_i    (rst_pin_i),
        .accept_o (src.pin)
    );

    rstgen_wdog #(.ENABLE(WDOG_ENABLE)) u_wdog (
        .clk       (clk),
        .por_i     (por_i),
        .sys_rst_i (sys_rst_o),
        .tick_i    (tick_1hz_i),
        .wr_i      (wd_wr_i),
        .clr_i     (wd_wdata_i[3]),
        .ien_i     (wd_wdata_i[0]),
        .rdata_o   (rd),
        .fire_o    (src.wdog)
    );

    assign sys_rst_o  = |src;
    assign wd_rdata_o = rd;

    rstgen_strobe u_stb (
        .clk      (clk),
        .por_i    (por_i),
        .rst_i    (sys_rst_o),
        .wr_i     (port_wr_i),
        .strobe_o (strobe_o)
    );
endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk #(
    parameter bit WDOG_ENABLE = 1'b1
) (
    input logic       clk,
    input logic       por_i,
    input logic       tick_1hz_i,
    input logic       wd_wr_i,
    input logic [3:0] wd_wdata_i,
    input logic [3:0] wd_rdata_o,
    input logic       sys_rst_o,
    input logic       strobe_o
);
    // R1
    cold_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(por_i) |-> sys_rst_o);

    // R3
    wd_count_step_chk: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && tick_1hz_i && !(wd_wr_i && wd_wdata_i[3]) && wd_rdata_o[2:1] != 2'd3)
        |=> (wd_rdata_o[2:1] == $past(wd_rdata_o[2:1]) + 2'd1));

    // R4
    wd_fire_chk: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && tick_1hz_i && !(wd_wr_i && wd_wdata_i[3]) && wd_rdata_o[2:1] == 2'd3)
        |=> (wd_rdata_o[2:1] == 2'd0) && (!WDOG_ENABLE || sys_rst_o));

    // R5
    wd_clear_chk: assert property (@(posedge clk) disable iff (por_i)
        (wd_wr_i && wd_wdata_i[3]) |=> (wd_rdata_o[2:1] == 2'd0));

    // R6
    ien_write_chk: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && wd_wr_i) |=> (wd_rdata_o[0] == $past(wd_wdata_i[0])));

    // R7
    rst_clears_reg_chk: assert property (@(posedge clk) disable iff (por_i)
        sys_rst_o |=> (wd_rdata_o == 4'd0));

    // R9
    strobe_in_rst_chk: assert property (@(posedge clk) disable iff (por_i)
        sys_rst_o |-> strobe_o);
endmodule

bind rstgen_top rstgen_chk #(.WDOG_ENABLE(WDOG_ENABLE)) u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .tick_1hz_i (tick_1hz_i),
    .wd_wr_i    (wd_wr_i),
    .wd_wdata_i (wd_wdata_i),
    .wd_rdata_o (wd_rdata_o),
    .sys_rst_o  (sys_rst_o),
    .strobe_o   (strobe_o)
);

// File: tb/rstgen_top_tb_top.sv
module rstgen_top_tb_top;
    localparam int COLD = 16;
    localparam int DEB  = 4;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       rst_pin_i = 1'b0;
    logic       tick_1hz_i = 1'b0;
    logic       wd_wr_i = 1'b0;
    logic [3:0] wd_wdata_i = 4'd0;
    logic       port_wr_i = 1'b0;
    logic [3:0] rd_a, rd_b;
    logic       rst_a, rst_b, stb_a, stb_b;

    always #2 clk = ~clk;

    rstgen_top #(.COLD_CYCLES(COLD), .DEBOUNCE_CYCLES(DEB), .WDOG_ENABLE(1'b1)) dut_i (
        .clk(clk), .por_i(por_i), .rst_pin_i(rst_pin_i), .tick_1hz_i(tick_1hz_i),
        .wd_wr_i(wd_wr_i), .wd_wdata_i(wd_wdata_i), .wd_rdata_o(rd_a),
        .port_wr_i(port_wr_i), .sys_rst_o(rst_a), .strobe_o(stb_a));

    rstgen_top #(.COLD_CYCLES(COLD), .DEBOUNCE_CYCLES(DEB), .WDOG_ENABLE(1'b0)) dut_nowd_i (
        .clk(clk), .por_i(por_i), .rst_pin_i(rst_pin_i), .tick_1hz_i(tick_1hz_i),
        .wd_wr_i(wd_wr_i), .wd_wdata_i(wd_wdata_i), .wd_rdata_o(rd_b),
        .port_wr_i(port_wr_i), .sys_rst_o(rst_b), .strobe_o(stb_b));

    typedef enum int {S_RST, S_STB, S_RD, S_RST_NW, S_RD_NW} sig_e;
    typedef struct {
        sig_e       sig;
        logic [3:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [3:0] sample(sig_e s);
        case (s)
            S_RST:    return {3'd0, rst_a};
            S_STB:    return {3'd0, stb_a};
            S_RD:     return rd_a;
            S_RST_NW: return {3'd0, rst_b};
            default:  return rd_b;
        endcase
    endfunction

    function automatic void compare(sig_e s, logic [3:0] e, string req);
        logic [3:0] act;
        act = sample(s);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, s.name(), act, e, $time);
        end
    endfunction

    // driver side: expectation for the sample taken just after the next rising edge
    task automatic expect_next(sig_e s, logic [3:0] e, string req);
        item_t it;
        it.sig = s; it.exp = e; it.req = req;
        q.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // monitor: pops every pending item after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                compare(it.sig, it.exp, it.req);
            end
        end
    end

    initial begin
        for (int n = 0; n < 5000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        // reset state under power-on: R1 R7 R9
        expect_next(S_RST, 4'd1, "R1");
        expect_next(S_STB, 4'd1, "R9");
        expect_next(S_RD, 4'd0, "R7");
        step();

        // cold-start release: R1
        por_i = 1'b0;
        for (int i = 1; i <= COLD; i++) begin
            expect_next(S_RST, (i < COLD) ? 4'd1 : 4'd0, "R1");
            expect_next(S_RST_NW, (i < COLD) ? 4'd1 : 4'd0, "R1");
            step();
            if (i == 3) begin
                #1 compare(S_STB, 4'd1, "R9");
            end
        end
        expect_next(S_RST, 4'd0, "R1");
        step();

        // three ticks: R3
        for (int k = 1; k <= 3; k++) begin
            tick_1hz_i = 1'b1;
            expect_next(S_RD, {1'b0, 2'(k), 1'b0}, "R3");
            expect_next(S_RD_NW, {1'b0, 2'(k), 1'b0}, "R3");
            step();
        end
        tick_1hz_i = 1'b0;

        // enable bit set: R6
        wd_wr_i = 1'b1; wd_wdata_i = 4'b0001;
        expect_next(S_RD, 4'b0111, "R6");
        step();
        wd_wr_i = 1'b0;

        // fourth tick at count 3: R4 R8
        tick_1hz_i = 1'b1;
        expect_next(S_RST, 4'd1, "R4");
        expect_next(S_RD, 4'b0001, "R4");
        expect_next(S_RST_NW, 4'd0, "R8");
        expect_next(S_RD_NW, 4'b0001, "R8");
        step();
        #1 compare(S_STB, 4'd1, "R9");
        tick_1hz_i = 1'b0;
        expect_next(S_RST, 4'd0, "R4");
        expect_next(S_RD, 4'd0, "R7");
        expect_next(S_RD_NW, 4'b0001, "R8");
        step();

        // clear behaviour: R5
        tick_1hz_i = 1'b1;
        expect_next(S_RD, 4'b0010, "R3");
        step();
        expect_next(S_RD, 4'b0100, "R3");
        step();
        tick_1hz_i = 1'b0;
        wd_wr_i = 1'b1; wd_wdata_i = 4'b1000;
        expect_next(S_RD, 4'b0000, "R5");
        step();
        tick_1hz_i = 1'b1;
        expect_next(S_RD, 4'b0000, "R5");
        step();
        wd_wr_i = 1'b0;
        expect_next(S_RD, 4'b0010, "R5");
        step();
        tick_1hz_i = 1'b0;

        // read-only bits ignored: R6
        wd_wr_i = 1'b1; wd_wdata_i = 4'b0111;
        expect_next(S_RD, 4'b0011, "R6");
        step();
        wd_wdata_i = 4'b0110;
        expect_next(S_RD, 4'b0010, "R6");
        step();
        wd_wdata_i = 4'b0001;
        expect_next(S_RD, 4'b0011, "R6");
        step();
        wd_wr_i = 1'b0;

        // short pin pulse rejected: R2
        rst_pin_i = 1'b1;
        for (int i = 1; i < DEB; i++) begin
            expect_next(S_RST, 4'd0, "R2");
            step();
        end
        rst_pin_i = 1'b0;
        expect_next(S_RST, 4'd0, "R2");
        expect_next(S_RD, 4'b0011, "R2");
        step();

        // long pin pulse accepted, ticks ignored meanwhile: R2 R7
        rst_pin_i = 1'b1;
        for (int i = 1; i <= DEB + 2; i++) begin
            tick_1hz_i = (i == DEB + 1);
            expect_next(S_RST, (i >= DEB) ? 4'd1 : 4'd0, "R2");
            step();
        end
        #1 compare(S_STB, 4'd1, "R9");
        tick_1hz_i = 1'b0;
        rst_pin_i = 1'b0;
        expect_next(S_RST, 4'd0, "R2");
        expect_next(S_RD, 4'd0, "R7");
        expect_next(S_RD_NW, 4'd0, "R7");
        step();

        // port write strobe: R10
        #1 compare(S_STB, 4'd0, "R10");
        port_wr_i = 1'b1;
        expect_next(S_STB, 4'd1, "R10");
        step();
        port_wr_i = 1'b0;
        #1 compare(S_STB, 4'd0, "R10");
        expect_next(S_STB, 4'd0, "R10");
        step();
        step();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule